// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects up to eight edge-triggered interrupt requests and presents the most urgent one to a processor. Software reaches it through a byte-wide register port with two addresses: a command address and a data address. After reset the controller stays silent until it has received a three-word setup sequence after a start command. That sequence gives the vector base, the cascade configuration and the mode options. From then on, a write to the data address loads the mask, and writes to the command address either end an interrupt or choose which internal register a command-address read returns.

Each request line is captured on its rising edge. Line 0 has the highest priority and line 7 the lowest. An unmasked request is raised on `int_out` only while no in-service line of equal or higher priority is active. A one-cycle acknowledge returns the vector. It also moves the line from pending to in-service, unless automatic end-of-interrupt mode is selected. If the request has gone by acknowledge time, the controller returns the lowest-priority vector and marks nothing in service. Software can detect this case.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, pending and in-service registers read 0x00, the mask reads 0xFF, command-address reads select the pending register, and `int_out` stays low until the setup sequence completes.
- R2: A command-address write with bit 4 set starts setup. The next three data-address writes are taken as the vector base (bits 7:3 kept), the cascade word and the mode word, in that order. Line n then yields vector base+n.
- R3: The cascade word written during setup is presented unchanged on `cascade_cfg`.
- R4: After setup, a data-address write loads the mask. A mask bit of 1 blocks its line from `int_out`. A data-address read returns the mask.
- R5: A pending bit is set by a rising edge on its request line. A line held high raises no further request once it has been acknowledged.
- R6: Priority is fixed with line 0 highest. A pending line is delivered only if no in-service bit at its own or a higher-priority index is set.
- R7: `int_out` is registered. It rises one cycle after a deliverable request exists and is low in the cycle that follows an acknowledge.
- R8: An acknowledge with a deliverable request returns vector base+n for the winning line n in the same cycle, clears pending bit n and sets in-service bit n.
- R9: When mode-word bit 1 is set, an acknowledge leaves the in-service register unchanged, so no end-of-interrupt is needed.
- R10: A command write of 0x60+n clears in-service bit n and no other bit.
- R11: A command write of 0x0A selects the pending register and 0x0B selects the in-service register for command-address reads. The choice persists, and other command values without bit 4 leave it unchanged.
- R12: An acknowledge with no deliverable request returns vector base+7 and leaves the in-service register unchanged, so in-service bit 7 reads 0.
- R13: A new start command clears the in-service register, returns the read choice to the pending register, drops `int_out` and keeps it low until the sequence completes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt to processor |
| int_ack | input | 1 | One-cycle acknowledge strobe |
| int_vector | output | 8 | Vector returned during acknowledge |
| cascade_cfg | output | 8 | Cascade word from setup |

## Verification
The bench goes after nesting. A lower-priority request that arrives while a higher line is in service must stay hidden, and a design that compares priorities the wrong way would raise it at once. It also masks a line between the interrupt and its acknowledge. A design without a spurious path would then hand out the masked vector or set an in-service bit. A held-high line is acknowledged and serviced to check that a level is not taken for repeated edges. The bench also checks that specific end-of-interrupt clears only its own bit, and that automatic end-of-interrupt mode leaves the in-service register empty after a re-setup.

// File: rtl/pic8_pkg.sv
// Shared types and command codes for the eight-line interrupt controller.
// Assumes a byte-wide register bus and eight request lines.
package pic8_pkg;
    typedef enum logic [1:0] {
        SU_IDLE,
        SU_BASE,
        SU_CASC,
        SU_MODE
    } setup_state_e;

    localparam logic [4:0] CMD_EOI_PREFIX = 5'b01100;
    localparam logic [7:0] CMD_SEL_PEND   = 8'h0A;
    localparam logic [7:0] CMD_SEL_SERV   = 8'h0B;
    localparam int         START_BIT      = 4;
    localparam int         AUTO_EOI_BIT   = 1;
endpackage

// File: rtl/pic8_cfg.sv
// Setup sequencer and register file: decodes bus writes into setup words,
// the mask, read selection and end-of-interrupt commands.
// Assumes writes are single-cycle strobes and address 0 is the command port.
module pic8_cfg
    import pic8_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int IDXW = $clog2(N_LINES),
    localparam int VBW  = 8 - IDXW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            addr,
    input  logic [7:0]      wdata,
    output logic            ready,
    output logic            start_cmd,
    output logic [7:0]      mask,
    output logic [VBW-1:0]  base_hi,
    output logic [7:0]      casc,
    output logic            auto_eoi,
    output logic            rd_serv,
    output logic            eoi_valid,
    output logic [IDXW-1:0] eoi_idx
);
    setup_state_e st;

    // Command decode shared by the sequencer and the in-service logic.
    always_comb begin
        start_cmd = wr && !addr && wdata[START_BIT];
        eoi_valid = wr && !addr && ready && !wdata[START_BIT]
                    && (wdata[7:3] == CMD_EOI_PREFIX);
        eoi_idx   = wdata[IDXW-1:0];
    end

    // Setup sequence, mask and read-select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SU_IDLE;
            ready    <= 1'b0;
            mask     <= 8'hFF;
            base_hi  <= '0;
            casc     <= 8'h00;
            auto_eoi <= 1'b0;
            rd_serv  <= 1'b0;
        end else if (start_cmd) begin
            st      <= SU_BASE;
            ready   <= 1'b0;
            rd_serv <= 1'b0;
        end else if (wr && addr) begin
            case (st)
                SU_BASE: begin base_hi <= wdata[7:IDXW]; st <= SU_CASC; end
                SU_CASC: begin casc <= wdata; st <= SU_MODE; end
                SU_MODE: begin
                    auto_eoi <= wdata[AUTO_EOI_BIT];
                    st       <= SU_IDLE;
                    ready    <= 1'b1;
                end
                default: if (ready) mask <= wdata;
            endcase
        end else if (wr && !addr && ready) begin
            if (wdata == CMD_SEL_PEND) rd_serv <= 1'b0;
            else if (wdata == CMD_SEL_SERV) rd_serv <= 1'b1;
        end
    end

    // R2: the mode word is the last one; it makes the controller ready.
    p_setup_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SU_MODE && wr && addr && !wdata[START_BIT] && !start_cmd) |=> ready);
    // R13: no readiness while the sequence is in flight.
    p_busy_not_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st != SU_IDLE) |-> !ready);
endmodule

// File: rtl/pic8_pend.sv
// Pending-request register: one bit per line set on a rising input edge
// and cleared when that line is accepted by an acknowledge.
// Assumes request inputs are synchronous to clk.
module pic8_pend #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq,
    input  logic [N_LINES-1:0] clr,
    output logic [N_LINES-1:0] pend
);
    logic [N_LINES-1:0] prev;

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        // Edge capture for one line; a fresh edge wins over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev[k] <= 1'b0;
                pend[k] <= 1'b0;
            end else begin
                prev[k] <= irq[k];
                pend[k] <= (pend[k] && !clr[k]) || (irq[k] && !prev[k]);
            end
        end

        // R5: a rising edge always leaves the line pending.
        p_edge_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[k] && !prev[k]) |=> pend[k]);
    end
endmodule

// File: rtl/pic8_prio.sv
// Fixed-priority resolver: finds the lowest-index unmasked pending line
// and blocks it when an in-service line of equal or higher priority exists.
// Purely combinational.
module pic8_prio #(
    parameter int N_LINES = 8,
    localparam int IDXW = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] req,
    input  logic [N_LINES-1:0] serv,
    output logic               hit,
    output logic [IDXW-1:0]    idx
);
    logic blocked;

    // Pick the winner and test the in-service bits at or above its priority.
    always_comb begin
        idx     = '0;
        blocked = 1'b0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDXW'(i);
        end
        for (int i = 0; i < N_LINES; i++) begin
            if (i <= int'(idx) && serv[i]) blocked = 1'b1;
        end
        hit = (|req) && !blocked;
    end
endmodule

// File: rtl/pic8_ctrl.sv
// Eight-line priority interrupt controller top: in-service register,
// registered interrupt output, vector generation and register read mux.
// Assumes the acknowledge is a single-cycle strobe synchronous to clk.
module pic8_ctrl #(
    parameter int N_LINES = 8,
    localparam int IDXW = $clog2(N_LINES),
    localparam int VBW  = 8 - IDXW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic               int_out,
    input  logic               int_ack,
    output logic [7:0]         int_vector,
    output logic [7:0]         cascade_cfg
);
    logic               ready, start_cmd, auto_eoi, rd_serv, eoi_valid;
    logic [7:0]         mask;
    logic [VBW-1:0]     base_hi;
    logic [IDXW-1:0]    eoi_idx, win_idx;
    logic [N_LINES-1:0] pend, serv, take_vec, eoi_vec;
    logic               win_hit, deliver, take;

    pic8_cfg #(.N_LINES(N_LINES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .ready(ready), .start_cmd(start_cmd),
        .mask(mask), .base_hi(base_hi), .casc(cascade_cfg),
        .auto_eoi(auto_eoi), .rd_serv(rd_serv), .eoi_valid(eoi_valid),
        .eoi_idx(eoi_idx)
    );

    pic8_pend #(.N_LINES(N_LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq(irq_in), .clr(take_vec), .pend(pend)
    );

    pic8_prio #(.N_LINES(N_LINES)) u_prio (
        .req(pend & ~mask), .serv(serv), .hit(win_hit), .idx(win_idx)
    );

    // Acknowledge acceptance, vector and read mux.
    always_comb begin
        deliver    = ready && win_hit;
        take       = int_ack && deliver;
        take_vec   = take ? (N_LINES'(1) << win_idx) : '0;
        eoi_vec    = eoi_valid ? (N_LINES'(1) << eoi_idx) : '0;
        int_vector = {base_hi, deliver ? win_idx : {IDXW{1'b1}}};
        bus_rdata  = bus_addr ? mask : (rd_serv ? serv : pend);
    end

    // In-service register: end-of-interrupt clears, acknowledge sets.
    always_ff @(posedge clk) begin
        if (!rst_n || start_cmd) serv <= '0;
        else serv <= (serv & ~eoi_vec) | (auto_eoi ? '0 : take_vec);
    end

    // Registered interrupt request to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n || start_cmd) int_out <= 1'b0;
        else int_out <= deliver && !int_ack;
    end

    // R1: no interrupt unless setup had completed the cycle before.
    p_int_needs_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> $past(ready));
    // R7: the cycle after an acknowledge the interrupt output is low.
    p_ack_drops_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> !int_out);
    // R8: an accepted line is in service afterwards in normal mode.
    p_ack_sets_serv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !auto_eoi && !start_cmd) |=> serv[$past(win_idx)]);
    // R9: automatic end-of-interrupt keeps the in-service register empty.
    p_auto_eoi_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && auto_eoi) |-> (serv == '0));
    // R10: a specific end-of-interrupt clears its bit.
    p_eoi_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !int_ack) |=> !serv[$past(eoi_idx)]);
    // R12: a spurious acknowledge leaves the in-service register unchanged.
    p_spurious_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !deliver && !eoi_valid && !start_cmd) |=> (serv == $past(serv)));
endmodule

// File: tb/pic8_ctrl_tb.sv
module pic8_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       int_out;
    logic       int_ack = 1'b0;
    logic [7:0] int_vector;
    logic [7:0] cascade_cfg;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] irr_m, isr_m, mask_m, v, r;

    pic8_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .int_out(int_out), .int_ack(int_ack), .int_vector(int_vector),
        .cascade_cfg(cascade_cfg)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] bits);
        @(negedge clk);
        irq_in = bits;
        @(negedge clk);
        irq_in = 8'h00;
    endtask

    task automatic do_ack(output logic [7:0] vec);
        @(negedge clk);
        int_ack = 1'b1;
        #1 vec = int_vector;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    // Expected winner: index 0..7, or 8 when nothing is deliverable.
    function automatic int pick(input logic [7:0] irr, input logic [7:0] msk,
                                input logic [7:0] isr);
        logic [7:0] req = irr & ~msk;
        for (int i = 0; i < 8; i++) begin
            if (req[i]) begin
                for (int j = 0; j <= i; j++) if (isr[j]) return 8;
                return i;
            end
        end
        return 8;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        rd(1'b1, r); chk("R1 mask", r, 8'hFF);
        rd(1'b0, r); chk("R1 pending", r, 8'h00);
        chk("R1 int_out", {7'd0, int_out}, 8'h00);

        // R1: a request before setup raises nothing.
        pulse(8'h20);
        settle();
        chk("R1 inactive", {7'd0, int_out}, 8'h00);

        // R2/R3: setup as master, base 0x20, slave on line 2, normal EOI.
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        chk("R3 cascade", cascade_cfg, 8'h04);
        wr(1'b1, 8'h00);
        settle();
        chk("R7 int raised", {7'd0, int_out}, 8'h01);

        // R8/R7/R11: acknowledge line 5.
        do_ack(v);
        chk("R2 R8 vector", v, 8'h25);
        chk("R7 int low after ack", {7'd0, int_out}, 8'h00);
        rd(1'b0, r); chk("R8 pending cleared", r, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); chk("R11 R8 in-service", r, 8'h20);

        // R6: lower line 6 is held back by in-service 5.
        pulse(8'h40);
        settle();
        chk("R6 lower blocked", {7'd0, int_out}, 8'h00);
        pulse(8'h04);
        settle();
        chk("R6 higher nests", {7'd0, int_out}, 8'h01);
        do_ack(v);
        chk("R6 vector", v, 8'h22);
        rd(1'b0, r); chk("R6 nested serv", r, 8'h24);
        wr(1'b0, 8'h62);
        rd(1'b0, r); chk("R10 only bit 2", r, 8'h20);
        settle();
        chk("R6 still blocked", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h65);
        settle();
        chk("R6 released", {7'd0, int_out}, 8'h01);
        do_ack(v);
        chk("R8 vector 6", v, 8'h26);
        wr(1'b0, 8'h66);
        rd(1'b0, r); chk("R10 cleared", r, 8'h00);

        // R5: a held level is one request only.
        @(negedge clk); irq_in = 8'h02;
        settle();
        do_ack(v);
        chk("R5 vector", v, 8'h21);
        wr(1'b0, 8'h61);
        settle();
        chk("R5 no retrigger", {7'd0, int_out}, 8'h00);
        @(negedge clk); irq_in = 8'h00;

        // R4: mask blocks; data address reads mask.
        wr(1'b1, 8'h08);
        rd(1'b1, r); chk("R4 mask read", r, 8'h08);
        pulse(8'h08);
        settle();
        chk("R4 masked", {7'd0, int_out}, 8'h00);

        // R12: request withdrawn by masking just before acknowledge.
        wr(1'b1, 8'h00);
        settle();
        chk("R4 unmasked", {7'd0, int_out}, 8'h01);
        wr(1'b1, 8'h08);
        do_ack(v);
        chk("R12 spurious vector", v, 8'h27);
        rd(1'b0, r); chk("R12 serv untouched", r, 8'h00);

        // R11: an unrelated command keeps the read choice.
        wr(1'b0, 8'h05);
        wr(1'b1, 8'h00);
        settle();
        do_ack(v);
        chk("R8 vector 3", v, 8'h23);
        rd(1'b0, r); chk("R11 choice persists", r, 8'h08);
        wr(1'b0, 8'h63);
        wr(1'b0, 8'h0A);
        rd(1'b0, r); chk("R11 pending select", r, 8'h00);
        wr(1'b0, 8'h0B);

        // Random phase against a bench model (R4, R6, R8, R10).
        irr_m = 8'h00; isr_m = 8'h00; mask_m = 8'h00;
        for (int k = 0; k < 40; k++) begin
            int w;
            logic [7:0] p;
            mask_m = 8'($urandom) & 8'($urandom);
            wr(1'b1, mask_m);
            p = 8'($urandom) & 8'($urandom);
            pulse(p);
            irr_m |= p;
            settle();
            w = pick(irr_m, mask_m, isr_m);
            chk("R6 random int_out", {7'd0, int_out}, (w != 8) ? 8'h01 : 8'h00);
            if (w != 8) begin
                do_ack(v);
                chk("R8 random vector", v, 8'h20 + 8'(w));
                isr_m[w] = 1'b1;
                irr_m[w] = 1'b0;
            end
            rd(1'b0, r); chk("R8 random serv", r, isr_m);
            if (isr_m != 8'h00 && $urandom_range(0, 1) == 1) begin
                int e = 0;
                for (int i = 7; i >= 0; i--) if (isr_m[i]) e = i;
                wr(1'b0, 8'h60 + 8'(e));
                isr_m[e] = 1'b0;
                rd(1'b0, r); chk("R10 random eoi", r, isr_m);
            end
        end
        wr(1'b1, 8'hFF);

        // R13/R9: re-setup as slave, base 0x28, identity 2, automatic EOI.
        wr(1'b0, 8'h11);
        rd(1'b0, r); chk("R13 select back to pending", r, irr_m);
        chk("R13 int low", {7'd0, int_out}, 8'h00);
        wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h03);
        chk("R3 slave identity", cascade_cfg, 8'h02);
        wr(1'b1, 8'hEF);
        pulse(8'h10);
        settle();
        do_ack(v);
        chk("R9 vector", v, 8'h2C);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); chk("R9 R13 serv empty", r, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule